// File: doc/BRIEF.md
# Link Training Sequence Generator

This block sits on the source side of a 16-bit word-slot data path. It makes the de-skew training pattern that the far end uses to line up its data and control lanes. In every slot it either forwards the word and control flag offered by the normal data mux, or it replaces them with a training word. `train_active` tells the mux that training owns the current slot.

A training sequence is one idle control word, then one or more 20-word patterns. Each pattern is ten training-control words followed by ten training-data words. After reset the block is in start-up mode. It keeps repeating patterns until the receiver reports valid status at the end of a pattern. From then on it is in periodic mode. An interval timer restarts with every sequence. When the timer expires, the block waits for a packet boundary from the mux and then inserts a sequence with a programmed number of patterns. A loss-of-sync pulse sends the block straight back to start-up training.

The controller has four named states. `ST_IDLE` emits the idle word. `ST_TCTL` emits the ten control words. `ST_TDAT` emits the ten data words. `ST_PASS` forwards the mux. The transitions are:
- `ST_IDLE` to `ST_TCTL` always.
- `ST_TCTL` to `ST_TDAT` after the tenth word.
- `ST_TDAT` to `ST_TCTL` after the tenth word, when more patterns are due.
- `ST_TDAT` to `ST_PASS` after the tenth word, when the sequence is complete.
- `ST_PASS` to `ST_IDLE` when the timer has expired and a boundary is present.
- Any state to `ST_IDLE` when loss-of-sync is seen.

Top module: `train_seq_gen`

## Requirements
- R1: While reset is held, and in the first slot after its release, the output is the idle word 16'h000F with the control flag at 1 and `train_active` at 1.
- R2: A sequence is exactly one idle word, followed by patterns. Each pattern is ten words 16'h0FFF with the control flag at 1, then ten words 16'hF000 with the control flag at 0.
- R3: In start-up mode, a pattern is followed directly by another pattern, with no idle word in between, while `status_valid` is low in the last data slot.
- R4: `status_valid` is sampled only in the last data slot of a pattern. A high level earlier in the pattern has no effect. A high level in that slot ends start-up training, and the next slot is forwarded.
- R5: When no training is due, `out_data` and `out_ctl` equal `mux_data` and `mux_ctl` in the same slot, and `train_active` is 0.
- R6: In periodic mode, with `pkt_boundary` held high, consecutive idle words are exactly `interval` slots apart, provided that `interval` exceeds the sequence length.
- R7: After the interval has expired, the block keeps forwarding while `pkt_boundary` is low. The idle word appears in the slot after the first slot in which `pkt_boundary` is high.
- R8: In periodic mode a sequence holds `repeat_cnt` patterns, as sampled in the idle slot. A value of 0 is treated as 1.
- R9: A high `loss_sync` in any slot makes the next slot an idle word. The block then returns to start-up mode and ignores `repeat_cnt` until valid status ends training.
- R10: In periodic mode the value of `status_valid` does not change the length of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-slot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_valid | input | 1 | Receiver reports valid FIFO status |
| loss_sync | input | 1 | Synchronisation lost; restart start-up training |
| pkt_boundary | input | 1 | Data mux is at a packet boundary in this slot |
| interval | input | IVL_W | Periodic training bound, in slots |
| repeat_cnt | input | REP_W | Patterns per periodic sequence (0 acts as 1) |
| mux_data | input | 16 | Word offered by the normal data mux |
| mux_ctl | input | 1 | Control flag offered by the normal data mux |
| out_data | output | 16 | Word driven onto the data path |
| out_ctl | output | 1 | Control flag driven onto the data path |
| train_active | output | 1 | Training owns the current slot |

## Verification
The bench builds the block with its defaults: a 16-bit interval timer, a 4-bit repeat field and ten words per half-pattern. The ports are then driven with small intervals of 30, 60 and 100 slots. These intervals make several periodic sequences, exact idle-to-idle spacing and boundary stalls happen within a few hundred slots. Repeat values of 0, 1 and 2 cover the floor at one pattern and the multi-pattern path. Loss-of-sync pulses placed mid-pattern and during forwarding bring the return to start-up mode within reach.

// File: rtl/train_pkg.sv
package train_pkg;

    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] IDLE_WORD = 16'h000F;
    localparam logic [WORD_W-1:0] TCTL_WORD = 16'h0FFF;
    localparam logic [WORD_W-1:0] TDAT_WORD = 16'hF000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TCTL = 2'd1,
        ST_TDAT = 2'd2,
        ST_PASS = 2'd3
    } tr_state_e;

endpackage

// File: rtl/train_ivl_timer.sv
module train_ivl_timer #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [IVL_W-1:0] interval,
    output logic             expired
);

    localparam logic [IVL_W-1:0] T_MAX = {IVL_W{1'b1}};

    logic [IVL_W-1:0] tmr_q;

    // Slots since the last idle word; saturates.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (restart) begin
            tmr_q <= {{(IVL_W-1){1'b0}}, 1'b1};
        end else if (tmr_q != T_MAX) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    assign expired = ({1'b0, tmr_q} + 1'b1) >= {1'b0, interval};

endmodule

// File: rtl/train_slot_ctr.sv
module train_slot_ctr #(
    parameter int PAT_HALF = 10,
    parameter int REP_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             dat_phase,
    output logic             slot_last,
    output logic [REP_W-1:0] pat_cnt
);

    localparam int SLOT_W = (PAT_HALF > 2) ? $clog2(PAT_HALF) : 1;
    localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(PAT_HALF - 1);
    localparam logic [REP_W-1:0]  PAT_MAX  = {REP_W{1'b1}};

    logic [SLOT_W-1:0] slot_q;

    assign slot_last = (slot_q == SLOT_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q  <= '0;
            pat_cnt <= '0;
        end else if (clr) begin
            slot_q  <= '0;
            pat_cnt <= '0;
        end else if (run) begin
            slot_q <= slot_last ? '0 : slot_q + 1'b1;
            if (dat_phase && slot_last && pat_cnt != PAT_MAX) begin
                pat_cnt <= pat_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/train_fsm.sv
module train_fsm
    import train_pkg::*;
#(
    parameter int REP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loss_sync,
    input  logic               status_valid,
    input  logic               pkt_boundary,
    input  logic               expired,
    input  logic               slot_last,
    input  logic [REP_W-1:0]   pat_cnt,
    input  logic [REP_W-1:0]   repeat_cnt,
    output tr_state_e          st_q,
    output logic [WORD_W-1:0]  trn_word,
    output logic               trn_ctl,
    output logic               trn_own
);

    tr_state_e        st_n;
    logic             startup_q, startup_n;
    logic [REP_W-1:0] rep_lim_q;
    logic             seq_done;

    assign seq_done = startup_q ? status_valid
                                : (({1'b0, pat_cnt} + 1'b1) >= {1'b0, rep_lim_q});

    // State register, mode flag and repeat limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            startup_q <= 1'b1;
            rep_lim_q <= {{(REP_W-1){1'b0}}, 1'b1};
        end else begin
            st_q      <= st_n;
            startup_q <= startup_n;
            if (st_q == ST_IDLE) begin
                rep_lim_q <= (repeat_cnt == '0) ? {{(REP_W-1){1'b0}}, 1'b1} : repeat_cnt;
            end
        end
    end

    // Next state.
    always_comb begin
        st_n      = st_q;
        startup_n = startup_q;
        unique case (st_q)
            ST_IDLE: st_n = ST_TCTL;
            ST_TCTL: if (slot_last) st_n = ST_TDAT;
            ST_TDAT: begin
                if (slot_last) begin
                    if (seq_done) begin
                        st_n      = ST_PASS;
                        startup_n = 1'b0;
                    end else begin
                        st_n = ST_TCTL;
                    end
                end
            end
            ST_PASS: if (expired && pkt_boundary) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
        if (loss_sync) begin
            st_n      = ST_IDLE;
            startup_n = 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        unique case (st_q)
            ST_IDLE: begin trn_word = IDLE_WORD; trn_ctl = 1'b1; trn_own = 1'b1; end
            ST_TCTL: begin trn_word = TCTL_WORD; trn_ctl = 1'b1; trn_own = 1'b1; end
            ST_TDAT: begin trn_word = TDAT_WORD; trn_ctl = 1'b0; trn_own = 1'b1; end
            default: begin trn_word = '0;        trn_ctl = 1'b0; trn_own = 1'b0; end
        endcase
    end

endmodule

// File: rtl/train_seq_gen.sv
module train_seq_gen
    import train_pkg::*;
#(
    parameter int IVL_W    = 16,
    parameter int REP_W    = 4,
    parameter int PAT_HALF = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status_valid,
    input  logic              loss_sync,
    input  logic              pkt_boundary,
    input  logic [IVL_W-1:0]  interval,
    input  logic [REP_W-1:0]  repeat_cnt,
    input  logic [WORD_W-1:0] mux_data,
    input  logic              mux_ctl,
    output logic [WORD_W-1:0] out_data,
    output logic              out_ctl,
    output logic              train_active
);

    tr_state_e         st;
    logic              expired, slot_last;
    logic [REP_W-1:0]  pat_cnt;
    logic [WORD_W-1:0] trn_word;
    logic              trn_ctl, trn_own;

    train_ivl_timer #(.IVL_W(IVL_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (st == ST_IDLE),
        .interval (interval),
        .expired  (expired)
    );

    train_slot_ctr #(.PAT_HALF(PAT_HALF), .REP_W(REP_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (st == ST_IDLE),
        .run       (st == ST_TCTL || st == ST_TDAT),
        .dat_phase (st == ST_TDAT),
        .slot_last (slot_last),
        .pat_cnt   (pat_cnt)
    );

    train_fsm #(.REP_W(REP_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .loss_sync    (loss_sync),
        .status_valid (status_valid),
        .pkt_boundary (pkt_boundary),
        .expired      (expired),
        .slot_last    (slot_last),
        .pat_cnt      (pat_cnt),
        .repeat_cnt   (repeat_cnt),
        .st_q         (st),
        .trn_word     (trn_word),
        .trn_ctl      (trn_ctl),
        .trn_own      (trn_own)
    );

    assign out_data     = trn_own ? trn_word : mux_data;
    assign out_ctl      = trn_own ? trn_ctl  : mux_ctl;
    assign train_active = trn_own;

endmodule

// File: rtl/train_seq_chk.sv
module train_seq_chk
    import train_pkg::*;
#(
    parameter int PAT_HALF = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loss_sync,
    input logic              pkt_boundary,
    input logic              train_active,
    input logic              out_ctl,
    input logic [WORD_W-1:0] out_data
);

    localparam int RW = $clog2(PAT_HALF + 2);
    localparam logic [RW-1:0] HALF = RW'(PAT_HALF);
    localparam logic [RW-1:0] HEND = RW'(PAT_HALF - 1);

    logic is_idle, is_ctl, is_dat;
    logic [RW-1:0] ctl_run, dat_run;

    assign is_idle = train_active && out_ctl  && out_data == IDLE_WORD;
    assign is_ctl  = train_active && out_ctl  && out_data == TCTL_WORD;
    assign is_dat  = train_active && !out_ctl && out_data == TDAT_WORD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_run <= '0;
            dat_run <= '0;
        end else begin
            ctl_run <= is_ctl ? ((ctl_run > HALF) ? ctl_run : ctl_run + 1'b1) : '0;
            dat_run <= is_dat ? ((dat_run > HALF) ? dat_run : dat_run + 1'b1) : '0;
        end
    end

    p_idle_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle && !loss_sync |=> is_ctl);

    p_ctl_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_run <= HALF);

    p_ctl_to_dat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctl && ctl_run == HEND && !loss_sync |=> is_dat);

    p_dat_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dat_run <= HALF);

    p_start_bnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_active) |-> ($past(pkt_boundary) || $past(loss_sync)));

    p_exit_dat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(train_active) |-> ($past(is_dat) && $past(dat_run) == HEND));

endmodule

bind train_seq_gen train_seq_chk #(.PAT_HALF(PAT_HALF)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .loss_sync    (loss_sync),
    .pkt_boundary (pkt_boundary),
    .train_active (train_active),
    .out_ctl      (out_ctl),
    .out_data     (out_data)
);

// File: tb/tb_train_seq_gen.sv
module tb_train_seq_gen;
    import train_pkg::*;

    localparam int IVL_W = 16;
    localparam int REP_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              status_valid = 1'b0;
    logic              loss_sync = 1'b0;
    logic              pkt_boundary = 1'b0;
    logic [IVL_W-1:0]  interval = '0;
    logic [REP_W-1:0]  repeat_cnt = '0;
    logic [WORD_W-1:0] mux_data = '0;
    logic              mux_ctl = 1'b0;
    logic [WORD_W-1:0] out_data;
    logic              out_ctl;
    logic              train_active;

    int checks = 0;
    int errors = 0;
    int slot_no = 0;
    int last_idle = 0;

    always #2 clk = ~clk;

    train_seq_gen #(.IVL_W(IVL_W), .REP_W(REP_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .status_valid (status_valid),
        .loss_sync    (loss_sync),
        .pkt_boundary (pkt_boundary),
        .interval     (interval),
        .repeat_cnt   (repeat_cnt),
        .mux_data     (mux_data),
        .mux_ctl      (mux_ctl),
        .out_data     (out_data),
        .out_ctl      (out_ctl),
        .train_active (train_active)
    );

    task automatic step();
        @(negedge clk);
        slot_no++;
    endtask

    task automatic chk(input logic [15:0] d, input logic c, input logic a, input string req);
        checks++;
        if (out_data !== d || out_ctl !== c || train_active !== a) begin
            errors++;
            $display("FAIL %s slot %0d: got %h/%b/%b expected %h/%b/%b",
                     req, slot_no, out_data, out_ctl, train_active, d, c, a);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(IDLE_WORD, 1'b1, 1'b1, req);
        last_idle = slot_no;
    endtask

    task automatic chk_pass(input string req);
        mux_data = 16'hA5C3 ^ 16'(slot_no * 37);
        mux_ctl  = slot_no[0];
        #1;
        chk(mux_data, mux_ctl, 1'b0, req);
    endtask

    // One 20-word pattern; status_valid driven per slot.
    task automatic run_pattern(input logic sv_mid, input logic sv_end, input string req);
        for (int i = 0; i < 20; i++) begin
            step();
            if (i < 10) chk(TCTL_WORD, 1'b1, 1'b1, req);
            else        chk(TDAT_WORD, 1'b0, 1'b1, req);
            status_valid = (i == 19) ? sv_end : sv_mid;
        end
    endtask

    task automatic pass_until_idle(input int limit, input string req, output int gap);
        gap = -1;
        for (int i = 0; i < limit; i++) begin
            step();
            if (train_active === 1'b1) begin
                gap = slot_no - last_idle;
                chk_idle(req);
                return;
            end
            chk_pass(req);
        end
        checks++;
        errors++;
        $display("FAIL %s: no idle word within %0d slots (got none, expected one)", req, limit);
    endtask

    task automatic t_reset();
        interval   = 16'd60;
        repeat_cnt = 4'd1;
        rst_n      = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(IDLE_WORD, 1'b1, 1'b1, "R1 in reset");
        rst_n   = 1'b1;
        slot_no = 0;
        chk_idle("R1 first slot");
    endtask

    task automatic t_startup();
        run_pattern(1'b0, 1'b0, "R2");
        run_pattern(1'b0, 1'b0, "R3");
        run_pattern(1'b1, 1'b0, "R4 mid-pattern status ignored");
        run_pattern(1'b0, 1'b1, "R4");
        step();
        status_valid = 1'b0;
        chk_pass("R5 after start-up");
    endtask

    task automatic t_boundary();
        pkt_boundary = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            chk_pass("R7 held off without boundary");
        end
        repeat_cnt   = 4'd2;
        pkt_boundary = 1'b1;
        step();
        chk_idle("R7 boundary starts sequence");
        run_pattern(1'b0, 1'b0, "R8 pattern 1 of 2");
        run_pattern(1'b0, 1'b0, "R10 status low, pattern 2 of 2");
        step();
        chk_pass("R8 two patterns then forward");
    endtask

    task automatic t_interval();
        int gap;
        repeat_cnt = 4'd0;
        pass_until_idle(300, "R6", gap);
        chk_int(gap, 60, "R6 spacing 60");
        run_pattern(1'b0, 1'b0, "R8 zero acts as one");
        step();
        chk_pass("R10 ends without status");
        interval = 16'd100;
        pass_until_idle(300, "R6", gap);
        chk_int(gap, 100, "R6 spacing 100");
        run_pattern(1'b1, 1'b1, "R10 status high, one pattern");
        step();
        status_valid = 1'b0;
        chk_pass("R10 length unchanged by status");
    endtask

    task automatic t_sync();
        int gap;
        repeat_cnt = 4'd1;
        interval   = 16'd30;
        pass_until_idle(300, "R6", gap);
        chk_int(gap, 30, "R6 spacing 30");
        for (int i = 0; i < 3; i++) begin
            step();
            chk(TCTL_WORD, 1'b1, 1'b1, "R9 before loss");
        end
        loss_sync = 1'b1;
        step();
        loss_sync = 1'b0;
        chk_idle("R9 idle after mid-pattern loss");
        run_pattern(1'b0, 1'b0, "R9 start-up again");
        run_pattern(1'b0, 1'b0, "R9 repeat_cnt ignored");
        run_pattern(1'b0, 1'b1, "R9");
        step();
        status_valid = 1'b0;
        chk_pass("R9 forward after status");
        pkt_boundary = 1'b0;
        step();
        chk_pass("R9 forwarding");
        loss_sync = 1'b1;
        step();
        loss_sync = 1'b0;
        chk_idle("R9 idle after loss while forwarding");
        run_pattern(1'b0, 1'b1, "R9");
        step();
        status_valid = 1'b0;
        chk_pass("R9 forward again");
    endtask

    initial begin
        t_reset();
        t_startup();
        t_boundary();
        t_interval();
        t_sync();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule